// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss. It receives an address-space identifier, a 32-bit virtual address and an access type (read or write). It walks a two-level table held in memory and returns either a 20-bit physical frame number with its permissions, or a fault.

Each address space has a root word held in an internal base file. The base file is loaded in two steps: a write that selects a slot, then a write that fills that slot. The root word and every entry in the tables use the same layout. Bit 31 grants read, bit 30 grants write, bit 29 marks the page nonsecure, and bits 19:0 hold a frame number. In a directory entry, bit 28 also marks it as pointing to a second-level table. The walker issues word reads through a request/response memory port.

The miss input and the memory request use valid/ready handshakes. A miss is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the result appears, so only one walk is ever in progress. A memory request holds its valid and address until `mem_req_ready` is high. Exactly one response cycle, flagged by `mem_rsp_valid`, is expected per accepted request. The response port has no back-pressure.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0. Every base slot holds zero.
- R2: A configuration write with `cfg_sel`=0 stores the low ASID_W bits of `cfg_wdata` as the slot index and ignores the upper bits. A write with `cfg_sel`=1 stores the full word into the slot selected by the last index write. The index is kept between data writes.
- R3: The first memory read is at the word-aligned address {root[19:0], va[31:22], 2'b00}.
- R4: The second memory read is at {dir_entry[19:0], va[21:12], 2'b00}.
- R5: A root word that is zero, or that lacks the permission the access needs, gives a fault with no memory read.
- R6: A directory entry that is zero, or that has bit 28 clear, gives a fault after exactly one read.
- R7: A second-level entry that is zero gives a fault after exactly two reads.
- R8: A read access faults when bit 31 is clear at any of the three levels. A write access faults when bit 30 is clear at any of the three levels.
- R9: A walk with no fault makes exactly two reads. It ends with a one-cycle `done`, with `done_fault`=0 and `done_pfn` equal to bits 19:0 of the second-level entry. `done_rd`, `done_wr` and `done_ns` are the AND of bits 31, 30 and 29 over the root, the directory entry and the second-level entry.
- R10: When `done_fault` is 1, `done_pfn`, `done_rd`, `done_wr` and `done_ns` are all zero.
- R11: `req_ready` is 0 from the acceptance of a miss until the cycle in which `done` is high, and it is 0 whenever `mem_req_valid` is 1. A stalled memory request keeps its address stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = slot index write, 1 = slot data write |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker idle and able to take a miss |
| req_asid | input | ASID_W | Address-space identifier of the miss |
| req_va | input | 32 | Virtual address of the miss |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk ended in a fault |
| done_pfn | output | 20 | Resolved physical frame number |
| done_rd | output | 1 | Combined read permission |
| done_wr | output | 1 | Combined write permission |
| done_ns | output | 1 | Combined nonsecure attribute |

## Verification
The bench builds the walker with ASID_W=4, which gives a 16-slot base file. Every slot can then be loaded and walked in one run, including slots that were never loaded. With the narrow index, the test can also write an index value that has bits set above the index width, which shows that those bits are dropped. The memory model stalls requests at random. Random walks mix valid entries with zero entries, entries missing the next-level flag, and entries with permissions removed, so every fault path is reached from many addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PFN_W    = 20;
  localparam int VPN_W    = 20;
  localparam int IDX_W    = 10;
  localparam int BIT_RD   = 31;
  localparam int BIT_WR   = 30;
  localparam int BIT_NS   = 29;
  localparam int BIT_NEXT = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT
  } walk_state_e;

  typedef enum logic [1:0] {
    LVL_ROOT,
    LVL_DIR,
    LVL_TBL
  } level_e;
endpackage

// File: rtl/ptw_base_file.sv
module ptw_base_file #(
  parameter int ASID_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [ASID_W-1:0] rd_asid,
  output logic [31:0]       rd_word
);
  localparam int DEPTH = 1 << ASID_W;

  logic [ASID_W-1:0] idx_q;
  logic [31:0]       slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) idx_q <= cfg_wdata[ASID_W-1:0];
      else          slot_q[idx_q] <= cfg_wdata;
    end
  end

  assign rd_word = slot_q[rd_asid];
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [31:0] entry,
  input  level_e      level,
  input  logic        is_write,
  output logic        fault
);
  logic perm_miss;
  logic link_miss;

  always_comb begin
    perm_miss = is_write ? !entry[BIT_WR] : !entry[BIT_RD];
    link_miss = (level == LVL_DIR) && !entry[BIT_NEXT];
    fault     = (entry == 32'd0) || perm_miss || link_miss;
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic             req_write,
  input  logic [31:0]      root_word,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic [31:0]      chk_entry,
  output level_e           chk_level,
  output logic             chk_write,
  input  logic             chk_fault,
  output logic             done,
  output logic             done_fault,
  output logic [PFN_W-1:0] done_pfn,
  output logic             done_rd,
  output logic             done_wr,
  output logic             done_ns
);
  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic             write_q;
  logic [PFN_W-1:0] ptr_q;
  logic [2:0]       perm_q;
  logic             done_q, fault_q;
  logic [PFN_W-1:0] pfn_q;
  logic [2:0]       perm_out_q;

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_req_addr  = (state_q == ST_TBL_REQ) ? {ptr_q, vpn_q[IDX_W-1:0], 2'b00}
                                                 : {ptr_q, vpn_q[VPN_W-1:IDX_W], 2'b00};

  always_comb begin
    chk_entry = (state_q == ST_IDLE) ? root_word : mem_rsp_data;
    chk_write = (state_q == ST_IDLE) ? req_write : write_q;
    unique case (state_q)
      ST_DIR_REQ, ST_DIR_WAIT: chk_level = LVL_DIR;
      ST_TBL_REQ, ST_TBL_WAIT: chk_level = LVL_TBL;
      default:                 chk_level = LVL_ROOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vpn_q      <= '0;
      write_q    <= 1'b0;
      ptr_q      <= '0;
      perm_q     <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      pfn_q      <= '0;
      perm_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vpn_q   <= req_va[31:12];
          write_q <= req_write;
          if (chk_fault) begin
            done_q     <= 1'b1;
            fault_q    <= 1'b1;
            pfn_q      <= '0;
            perm_out_q <= '0;
          end else begin
            ptr_q   <= root_word[PFN_W-1:0];
            perm_q  <= root_word[BIT_RD:BIT_NS];
            state_q <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_TBL_REQ: if (mem_req_ready) state_q <= ST_TBL_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (chk_fault) begin
            done_q     <= 1'b1;
            fault_q    <= 1'b1;
            pfn_q      <= '0;
            perm_out_q <= '0;
            state_q    <= ST_IDLE;
          end else begin
            ptr_q   <= mem_rsp_data[PFN_W-1:0];
            perm_q  <= perm_q & mem_rsp_data[BIT_RD:BIT_NS];
            state_q <= ST_TBL_REQ;
          end
        end
        ST_TBL_WAIT: if (mem_rsp_valid) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (chk_fault) begin
            fault_q    <= 1'b1;
            pfn_q      <= '0;
            perm_out_q <= '0;
          end else begin
            fault_q    <= 1'b0;
            pfn_q      <= mem_rsp_data[PFN_W-1:0];
            perm_out_q <= perm_q & mem_rsp_data[BIT_RD:BIT_NS];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign done_fault = fault_q;
  assign done_pfn   = pfn_q;
  assign done_rd    = perm_out_q[2];
  assign done_wr    = perm_out_q[1];
  assign done_ns    = perm_out_q[0];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ASID_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              done_fault,
  output logic [19:0]       done_pfn,
  output logic              done_rd,
  output logic              done_wr,
  output logic              done_ns
);
  logic [31:0] root_word;
  logic [31:0] chk_entry;
  level_e      chk_level;
  logic        chk_write;
  logic        chk_fault;

  ptw_base_file #(.ASID_W(ASID_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .rd_asid  (req_asid),
    .rd_word  (root_word)
  );

  ptw_entry_check u_check (
    .entry   (chk_entry),
    .level   (chk_level),
    .is_write(chk_write),
    .fault   (chk_fault)
  );

  ptw_walk_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .req_write    (req_write),
    .root_word    (root_word),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .chk_entry    (chk_entry),
    .chk_level    (chk_level),
    .chk_write    (chk_write),
    .chk_fault    (chk_fault),
    .done         (done),
    .done_fault   (done_fault),
    .done_pfn     (done_pfn),
    .done_rd      (done_rd),
    .done_wr      (done_wr),
    .done_ns      (done_ns)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        done_fault,
  input logic [19:0] done_pfn,
  input logic        done_rd,
  input logic        done_wr,
  input logic        done_ns
);
  assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_fault_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_pfn == 20'd0 && !done_rd && !done_wr && !done_ns));

  assert_grant_has_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fault) |-> (done_rd || done_wr));
endmodule

bind pt_walker ptw_checker i_ptw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .done         (done),
  .done_fault   (done_fault),
  .done_pfn     (done_pfn),
  .done_rd      (done_rd),
  .done_wr      (done_wr),
  .done_ns      (done_ns)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int ASID_W = 4;
  localparam int SLOTS = 1 << ASID_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [31:0] req_va = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done, done_fault, done_rd, done_wr, done_ns;
  logic [19:0] done_pfn;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] roots [SLOTS];
  int nreads = 0;
  logic [31:0] rd_log [2];
  logic pend = 1'b0;
  logic [31:0] pend_addr = '0;

  pt_walker #(.ASID_W(ASID_W)) i_pt_walker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mread(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic perm_ok(logic [31:0] e, logic wr);
    return wr ? e[30] : e[31];
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory model: random stall on requests, response one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mread(pend_addr);
        pend = 1'b0;
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pend_addr = mem_req_addr;
        if (nreads < 2) rd_log[nreads] = mem_req_addr;
        nreads++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual %0d expected below 150000", cycles);
        summary();
      end
    end
  end

  task automatic cfg_write(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_root(int asid, logic [31:0] w);
    cfg_write(1'b0, 32'(asid));
    cfg_write(1'b1, w);
    roots[asid] = w;
  endtask

  task automatic walk(string rq, int asid, logic [31:0] va, logic wr);
    logic e_fault; logic [19:0] e_pfn; logic [2:0] e_perm; int e_nr;
    logic [31:0] a1, a2, d, t, b;
    bit got; int cyc; bit ready_bad;
    // expected result from the requirements
    e_fault = 1'b0; e_pfn = '0; e_perm = 3'b000; e_nr = 0; a1 = '0; a2 = '0;
    b = roots[asid];
    if (b == 0 || !perm_ok(b, wr)) e_fault = 1'b1;
    else begin
      a1 = {b[19:0], va[31:22], 2'b00}; e_nr = 1; d = mread(a1);
      if (d == 0 || !d[28] || !perm_ok(d, wr)) e_fault = 1'b1;
      else begin
        a2 = {d[19:0], va[21:12], 2'b00}; e_nr = 2; t = mread(a2);
        if (t == 0 || !perm_ok(t, wr)) e_fault = 1'b1;
        else begin e_pfn = t[19:0]; e_perm = b[31:29] & d[31:29] & t[31:29]; end
      end
    end
    @(negedge clk);
    nreads = 0;
    req_valid = 1'b1; req_asid = ASID_W'(asid); req_va = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_va = $urandom; req_write = $urandom;
    got = 0; cyc = 0; ready_bad = 0;
    while (!got && cyc < 100) begin
      if (done) got = 1;
      else begin
        if (req_ready) ready_bad = 1;
        @(negedge clk); cyc++;
      end
    end
    chk({rq, " R11 done seen"}, 64'(got), 64'd1);
    chk({rq, " R11 ready low during walk"}, 64'(ready_bad), 64'd0);
    chk({rq, " fault"}, 64'(done_fault), 64'(e_fault));
    chk({rq, " R9 pfn"}, 64'(done_pfn), 64'(e_pfn));
    chk({rq, " R9 perms"}, 64'({done_rd, done_wr, done_ns}), 64'(e_perm));
    chk({rq, " read count"}, 64'(nreads), 64'(e_nr));
    if (e_nr >= 1) chk({rq, " R3 dir addr"}, 64'(rd_log[0]), 64'(a1));
    if (e_nr >= 2) chk({rq, " R4 tbl addr"}, 64'(rd_log[1]), 64'(a2));
  endtask

  function automatic logic [31:0] mk(logic [2:0] attr, logic nxt, logic [19:0] pfn);
    return {attr, nxt, 8'd0, pfn};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < SLOTS; i++) roots[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 mem idle", 64'(mem_req_valid), 64'd0);

    // R1/R5: unloaded slot faults with no reads
    walk("R5 empty root", 2, 32'h1234_5000, 1'b0);

    // R6: zero directory entry, and entry missing next flag
    load_root(3, mk(3'b111, 1'b0, 20'h00103));
    walk("R6 zero dir", 3, 32'h0040_1000, 1'b0);
    mem[{20'h00103, 10'h001, 2'b00}] = mk(3'b111, 1'b0, 20'h10001);
    walk("R6 no next", 3, 32'h0040_1000, 1'b0);

    // R7: zero table entry after valid directory
    mem[{20'h00103, 10'h001, 2'b00}] = mk(3'b111, 1'b1, 20'h10001);
    walk("R7 zero tbl", 3, 32'h0040_1000, 1'b1);

    // R9: full success
    mem[{20'h10001, 10'h001, 2'b00}] = mk(3'b101, 1'b0, 20'hABCDE);
    walk("R9 success read", 3, 32'h0040_1000, 1'b0);
    // R8: write blocked by table level
    walk("R8 write denied", 3, 32'h0040_1000, 1'b1);
    // R8: read blocked at root
    load_root(4, mk(3'b010, 1'b0, 20'h00104));
    walk("R8 root no read", 4, 32'h0040_1000, 1'b0);

    // R2: index keeps upper bits dropped; persists across data writes
    cfg_write(1'b0, 32'hFFFF_FF25);
    cfg_write(1'b1, mk(3'b000, 1'b0, 20'h00999));
    cfg_write(1'b1, mk(3'b111, 1'b0, 20'h00105));
    roots[5] = mk(3'b111, 1'b0, 20'h00105);
    mem[{20'h00105, 10'h3FF, 2'b00}] = mk(3'b111, 1'b1, 20'h12345);
    mem[{20'h12345, 10'h2AA, 2'b00}] = mk(3'b110, 1'b0, 20'h0F00D);
    walk("R2 index persist", 5, 32'hFFEA_A000, 1'b1);

    // constrained random walks
    for (int n = 0; n < 300; n++) begin
      int asid; logic [31:0] va; logic [2:0] at; int pick; logic wr;
      asid = $urandom % SLOTS;
      va = $urandom;
      wr = $urandom;
      if (roots[asid] == 0 || ($urandom % 10) == 0) begin
        at = (($urandom % 4) == 0) ? 3'($urandom) : 3'b111;
        load_root(asid, (($urandom % 12) == 0) ? 32'd0 : mk(at, 1'b0, 20'h00100 + 20'(asid)));
      end
      if (roots[asid] != 0) begin
        logic [31:0] da; logic [19:0] tf;
        da = {roots[asid][19:0], va[31:22], 2'b00};
        pick = $urandom % 10;
        tf = 20'h10000 | 20'($urandom % 65536);
        at = (($urandom % 4) == 0) ? 3'($urandom) : 3'b111;
        if (pick == 0) mem[da] = 32'd0;
        else if (pick == 1) mem[da] = mk(at, 1'b0, tf);
        else mem[da] = mk(at, 1'b1, tf);
        if (mem[da][28]) begin
          at = (($urandom % 4) == 0) ? 3'($urandom) : 3'b111;
          mem[{mem[da][19:0], va[21:12], 2'b00}] =
            (($urandom % 10) == 0) ? 32'd0 : mk(at, 1'b0, 20'($urandom));
        end
      end
      walk("R8 R9 random", asid, va, wr);
    end
    summary();
  end
endmodule